// File: doc/BRIEF.md
# Receive Byte Holding Register with Read-Overrun Detection

This block sits behind the serial shifter of a synchronous serial port that can act as bus master. Each time a byte transfer finishes, the shifter pulses a completion strobe together with the byte it received. The block copies that byte into a readable data register, where software or a DMA engine picks it up with a register-bus read strobe. The shifter is the first stage and this register is the second. Because of that, an earlier byte stays readable for the whole duration of the next transfer. It is replaced only when that next transfer completes.

The block keeps a flag that says whether the byte now in the data register has been read. If a transfer completes while that flag is still set, the byte in the register was never read and is now lost. This is a read overrun. When the port is a master and overrun detection is enabled, an overrun sets a sticky status bit and raises the interrupt. Software clears both by writing 1 to the status bit. In slave mode, or with detection disabled, the status bit is held at 0.

Top module: `rx_hold_ovr`

## Requirements
- R1: After reset, `rdData` is 0, and `ovrFlag` and `irq` are both 0.
- R2: A cycle with `byteDone` high loads `rxByte` into `rdData`, visible from the next clock edge.
- R3: In a cycle without `byteDone`, `rdData` keeps its value, whether or not `dataRd` or `ovrClrW1` is high.
- R4: If `byteDone` arrives while the byte in `rdData` is still unread, with `isMaster` and `ovrEnable` both 1, `ovrFlag` goes to 1 on the next edge.
- R5: If `dataRd` and `byteDone` are high in the same cycle, the read counts as happening first. No overrun is detected in that cycle.
- R6: If `dataRd` is pulsed at any time between two completions, the second completion does not cause an overrun.
- R7: On an overrun, the newly received byte replaces the unread one in `rdData`.
- R8: In any cycle in which `isMaster` or `ovrEnable` is 0, `ovrFlag` is 0 from the next edge. A flag that was already set is discarded and does not come back when detection is re-enabled.
- R9: `irq` is high in exactly the cycles in which `ovrFlag` is high.
- R10: `ovrClrW1` high clears `ovrFlag` and `irq` on the next edge. If an overrun is detected in the same cycle, the set wins.
- R11: The unread flag is set by every completion and cleared by a read. A read when nothing is unread has no effect on later overrun detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteDone | input | 1 | One-cycle strobe: a byte transfer has completed |
| rxByte | input | DATA_W | Byte received in the completed transfer |
| dataRd | input | 1 | One-cycle strobe: the data register is read by software or DMA |
| rdData | output | DATA_W | Current content of the readable data register |
| isMaster | input | 1 | 1 when the port is configured as master |
| ovrEnable | input | 1 | Read-overrun detection and interrupt enable |
| ovrClrW1 | input | 1 | Write of 1 to the overrun status bit |
| ovrFlag | output | 1 | Sticky read-overrun status bit |
| irq | output | 1 | Overrun interrupt request |

## Verification
The hardest case to reach is the exact cycle in which a completion, a read and a status clear coincide, or a completion arrives just after detection has been switched on or off. Free-running traffic almost never lines these up. The bench therefore drives each strobe on its own chosen cycle. It first leaves an unread byte in place, then lands `byteDone` together with `dataRd` or `ovrClrW1` in one cycle. It also toggles `isMaster` and `ovrEnable` around an already-set flag to check that the flag is discarded.

// File: rtl/rx_hold_pkg.sv
package rx_hold_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic loadByte;
  } rxStrobes_t;
endpackage

// File: rtl/rx_hold_dp.sv
module rx_hold_dp #(
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  rx_hold_pkg::rxStrobes_t strobes,
  input  logic [DATA_W-1:0]       rxByte,
  output logic [DATA_W-1:0]       rdData
);
  logic [DATA_W-1:0] holdQ;

  always_ff @(posedge clk) begin
    if (!rstN)                holdQ <= '0;
    else if (strobes.loadByte) holdQ <= rxByte;
  end

  assign rdData = holdQ;
endmodule

// File: rtl/rx_hold_ctrl.sv
module rx_hold_ctrl (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    byteDone,
  input  logic                    dataRd,
  input  logic                    isMaster,
  input  logic                    ovrEnable,
  input  logic                    ovrClrW1,
  output rx_hold_pkg::rxStrobes_t strobes,
  output logic                    ovrFlag,
  output logic                    irq
);
  logic unreadQ;
  logic flagQ;
  logic irqQ;
  logic overrun;
  logic detectOn;
  logic flagNext;

  // a read in the completion cycle is taken as coming first
  assign overrun  = byteDone && unreadQ && !dataRd;
  assign detectOn = isMaster && ovrEnable;

  always_comb begin
    if (!detectOn)     flagNext = 1'b0;
    else if (overrun)  flagNext = 1'b1;
    else if (ovrClrW1) flagNext = 1'b0;
    else               flagNext = flagQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      unreadQ <= 1'b0;
      flagQ   <= 1'b0;
      irqQ    <= 1'b0;
    end else begin
      if (byteDone)    unreadQ <= 1'b1;
      else if (dataRd) unreadQ <= 1'b0;
      flagQ <= flagNext;
      irqQ  <= flagNext;
    end
  end

  assign strobes.loadByte = byteDone;
  assign ovrFlag          = flagQ;
  assign irq              = irqQ;
endmodule

// File: rtl/rx_hold_ovr.sv
module rx_hold_ovr #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteDone,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              dataRd,
  output logic [DATA_W-1:0] rdData,
  input  logic              isMaster,
  input  logic              ovrEnable,
  input  logic              ovrClrW1,
  output logic              ovrFlag,
  output logic              irq
);
  rx_hold_pkg::rxStrobes_t strobes;

  rx_hold_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .byteDone(byteDone), .dataRd(dataRd),
    .isMaster(isMaster), .ovrEnable(ovrEnable), .ovrClrW1(ovrClrW1),
    .strobes(strobes), .ovrFlag(ovrFlag), .irq(irq)
  );

  rx_hold_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rxByte(rxByte), .rdData(rdData)
  );
endmodule

// File: rtl/rx_hold_ovr_chk.sv
module rx_hold_ovr_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              byteDone,
  input logic [DATA_W-1:0] rxByte,
  input logic              dataRd,
  input logic [DATA_W-1:0] rdData,
  input logic              isMaster,
  input logic              ovrEnable,
  input logic              ovrClrW1,
  input logic              ovrFlag,
  input logic              irq
);
  // independent view of whether the held byte was read
  logic pend;
  always_ff @(posedge clk) begin
    if (!rstN)         pend <= 1'b0;
    else if (byteDone) pend <= 1'b1;
    else if (dataRd)   pend <= 1'b0;
  end

  // R2
  load_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    byteDone |=> rdData == $past(rxByte));
  // R3
  hold_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    !byteDone |=> $stable(rdData));
  // R4
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteDone && pend && !dataRd && isMaster && ovrEnable) |=> ovrFlag);
  // R5
  ovr_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovrFlag) |-> $past(byteDone && pend && !dataRd));
  // R8
  ovr_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(isMaster && ovrEnable) |=> !ovrFlag);
  // R9
  irq_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq == ovrFlag);
  // R10
  ovr_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovrClrW1 && !byteDone) |=> !ovrFlag);
endmodule

bind rx_hold_ovr rx_hold_ovr_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/rx_hold_ovr_test.sv
module rx_hold_ovr_test;
  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic byteDone = 1'b0;
  logic [DATA_W-1:0] rxByte = '0;
  logic dataRd = 1'b0;
  logic isMaster = 1'b1;
  logic ovrEnable = 1'b1;
  logic ovrClrW1 = 1'b0;
  logic [DATA_W-1:0] rdData;
  logic ovrFlag;
  logic irq;
  int runCnt = 0;
  int failCnt = 0;

  always #2 clk = ~clk;

  rx_hold_ovr #(.DATA_W(DATA_W)) uut (
    .clk(clk), .rstN(rstN), .byteDone(byteDone), .rxByte(rxByte),
    .dataRd(dataRd), .rdData(rdData), .isMaster(isMaster),
    .ovrEnable(ovrEnable), .ovrClrW1(ovrClrW1), .ovrFlag(ovrFlag), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    runCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive strobes for one cycle (from a negedge), end at the next negedge
  task automatic step(input logic done, input logic [DATA_W-1:0] b,
                      input logic rd, input logic clr);
    byteDone = done; rxByte = b; dataRd = rd; ovrClrW1 = clr;
    @(negedge clk);
    byteDone = 1'b0; dataRd = 1'b0; ovrClrW1 = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 rdData", rdData, 0);
    check("R1 ovrFlag", ovrFlag, 0);
    check("R1 irq", irq, 0);
  endtask

  task automatic t_load();
    step(1, 8'hA5, 0, 0);
    check("R2 load", rdData, 8'hA5);
    step(0, 8'h5A, 1, 0);
    step(0, 8'h77, 0, 1);
    check("R3 hold", rdData, 8'hA5);
    step(1, 8'h3C, 0, 0);
    check("R6 read between", ovrFlag, 0);
    check("R2 load2", rdData, 8'h3C);
  endtask

  task automatic t_overrun();
    step(0, 0, 1, 0);
    step(1, 8'h11, 0, 0);
    step(0, 0, 0, 0);
    check("R4 no flag yet", ovrFlag, 0);
    step(1, 8'h22, 0, 0);
    check("R4 flag", ovrFlag, 1);
    check("R9 irq", irq, 1);
    check("R7 new byte", rdData, 8'h22);
    step(0, 0, 0, 0);
    check("R4 sticky", ovrFlag, 1);
    step(0, 0, 0, 1);
    check("R10 clr flag", ovrFlag, 0);
    check("R10 clr irq", irq, 0);
  endtask

  task automatic t_sameCycle();
    // 8'h22 still unread here
    step(1, 8'h33, 1, 0);
    check("R5 read first", ovrFlag, 0);
    check("R5 data", rdData, 8'h33);
    step(1, 8'h44, 0, 1);
    check("R10 set wins", ovrFlag, 1);
    check("R9 irq set", irq, 1);
    step(0, 0, 1, 1);
  endtask

  task automatic t_gate();
    isMaster = 1'b0;
    step(1, 8'h55, 0, 0);
    step(1, 8'h66, 0, 0);
    check("R8 slave", ovrFlag, 0);
    check("R8 slave irq", irq, 0);
    isMaster = 1'b1; ovrEnable = 1'b0;
    step(1, 8'h67, 0, 0);
    check("R8 disabled", ovrFlag, 0);
    ovrEnable = 1'b1;
    step(1, 8'h68, 0, 0);
    check("R8 enabled again", ovrFlag, 1);
    ovrEnable = 1'b0;
    step(0, 0, 0, 0);
    check("R8 discard", ovrFlag, 0);
    ovrEnable = 1'b1;
    step(0, 0, 0, 0);
    check("R8 not restored", ovrFlag, 0);
    check("R8 irq", irq, 0);
  endtask

  task automatic t_readTwice();
    step(0, 0, 1, 0);
    step(0, 0, 1, 0);
    step(1, 8'h99, 0, 0);
    check("R11 extra read", ovrFlag, 0);
    step(0, 0, 0, 0);
    step(1, 8'h9A, 0, 0);
    check("R11 unread set", ovrFlag, 1);
    check("R7 replaced", rdData, 8'h9A);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rstN = 1'b1;
        t_reset();
        t_load();
        t_overrun();
        t_sameCycle();
        t_gate();
        t_readTwice();
      end
      begin
        repeat (5000) @(posedge clk);
        runCnt++; failCnt++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end
endmodule